// File: doc/BRIEF.md
# Reorder Buffer Commit Queue

This block is a circular queue that keeps the results of out-of-order, speculatively executed instructions until they can retire in program order. Issue logic claims an entry at the tail for each instruction and records what kind of instruction it is and which register it targets. Execution units later report completion by entry index, with the result value and two status bits: a fault bit and a branch-misprediction bit.

Each cycle the oldest entry is examined. It retires only once its result has arrived. A retiring register instruction drives the register-file write. A retiring store only emits a release strobe to the memory side. A correctly predicted branch changes nothing. A mispredicted branch at the head retires and then discards every younger entry while raising a redirect. A faulting entry at the head writes nothing, raises an exception and empties the queue. An external flush input empties the queue at once.

Top module: `commit_queue`

## Requirements
- R1: After reset the queue is empty. `alloc_ready` is 1, `alloc_idx` is 0 and every commit output is 0.
- R2: An allocation is accepted when `alloc_valid` and `alloc_ready` are both 1. It takes the entry numbered `alloc_idx`. The next allocation index is one higher, wrapping from DEPTH-1 to 0.
- R3: While DEPTH entries are held, `alloc_ready` is 0 and `alloc_valid` has no effect.
- R4: Entries retire strictly oldest-first and at most one per cycle. An entry retires only after its completion has been received, so a younger finished entry waits behind an older unfinished one.
- R5: Kind code 2'b00 marks a register instruction. When one retires, `commit_reg_we` is 1 for that cycle, with its destination on `commit_dest` and its completion value on `commit_value`.
- R6: Kind code 2'b01 marks a store. When one retires, `commit_store` is 1 and `commit_reg_we` stays 0.
- R7: Kind code 2'b10 marks a branch. A branch completed without the mispredict bit retires with every commit output at 0.
- R8: A branch completed with the mispredict bit raises `commit_redirect` when it retires. All younger entries are discarded, and the next allocation index is 0.
- R9: An entry completed with the fault bit raises `commit_exc` when it reaches the head. It writes neither register nor store, and all entries are discarded.
- R10: While `flush_in` is 1, no commit output is raised and `alloc_ready` is 0. After that edge the queue is empty, with the next allocation index 0.
- R11: A completion naming an entry that is not allocated is ignored. An entry allocated there later still waits for its own completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Request to allocate an entry |
| alloc_kind | input | 2 | Instruction kind: 00 register, 01 store, 10 branch |
| alloc_dest | input | REG_W | Destination register number |
| alloc_ready | output | 1 | Allocation can be accepted this cycle |
| alloc_idx | output | IDX_W | Entry index given to the next allocation |
| done_valid | input | 1 | Completion report |
| done_idx | input | IDX_W | Entry index being completed |
| done_value | input | DATA_W | Result value |
| done_fault | input | 1 | Instruction raised an exception |
| done_mispredict | input | 1 | Branch was mispredicted |
| flush_in | input | 1 | Discard all entries |
| commit_reg_we | output | 1 | Register-file write strobe |
| commit_dest | output | REG_W | Register written at commit |
| commit_value | output | DATA_W | Value written at commit |
| commit_store | output | 1 | Store release strobe |
| commit_redirect | output | 1 | Mispredicted branch retired, fetch must redirect |
| commit_exc | output | 1 | Faulting instruction reached the head |

## Verification
The bench builds the queue with DEPTH 4, 4-bit register numbers and 16-bit values. With four entries, every one of the 24 orders in which a full queue's entries can complete can be swept. The full condition is reached after four allocations, and repeated runs carry both pointers across the wrap point many times. Streaming allocation and completion in the same cycle, mispredicted branches, faults on register and store entries, external flush and stray completions are each run against a bench model of occupancy, order and per-entry state.

// File: rtl/commit_queue.sv
module commit_queue #(
  parameter int DEPTH = 8,
  parameter int REG_W = 5,
  parameter int DATA_W = 32,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  input  logic [1:0]        alloc_kind,
  input  logic [REG_W-1:0]  alloc_dest,
  output logic              alloc_ready,
  output logic [IDX_W-1:0]  alloc_idx,
  input  logic              done_valid,
  input  logic [IDX_W-1:0]  done_idx,
  input  logic [DATA_W-1:0] done_value,
  input  logic              done_fault,
  input  logic              done_mispredict,
  input  logic              flush_in,
  output logic              commit_reg_we,
  output logic [REG_W-1:0]  commit_dest,
  output logic [DATA_W-1:0] commit_value,
  output logic              commit_store,
  output logic              commit_redirect,
  output logic              commit_exc
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [1:0] KIND_REG = 2'b00;
  localparam logic [1:0] KIND_ST  = 2'b01;
  localparam logic [1:0] KIND_BR  = 2'b10;

  logic [DEPTH-1:0]  vld_q, rdy_q, flt_q, mis_q;
  logic [1:0]        kind_q [DEPTH];
  logic [REG_W-1:0]  dest_q [DEPTH];
  logic [DATA_W-1:0] val_q  [DEPTH];
  logic [IDX_W-1:0]  head_q, tail_q;
  logic [CNT_W-1:0]  cnt_q;

  function automatic logic [IDX_W-1:0] bump(input logic [IDX_W-1:0] p);
    return (p == IDX_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  logic       head_go, head_flt, wipe, take, pop, done_hit;
  logic [1:0] head_kind;

  assign head_go   = vld_q[head_q] & rdy_q[head_q] & ~flush_in;
  assign head_flt  = flt_q[head_q];
  assign head_kind = kind_q[head_q];

  assign commit_exc      = head_go & head_flt;
  assign commit_reg_we   = head_go & ~head_flt & (head_kind == KIND_REG);
  assign commit_store    = head_go & ~head_flt & (head_kind == KIND_ST);
  assign commit_redirect = head_go & ~head_flt & (head_kind == KIND_BR) & mis_q[head_q];
  assign commit_dest     = dest_q[head_q];
  assign commit_value    = val_q[head_q];

  assign wipe        = flush_in | commit_exc | commit_redirect;
  assign alloc_ready = (cnt_q != CNT_W'(DEPTH)) & ~wipe;
  assign alloc_idx   = tail_q;
  assign take        = alloc_valid & alloc_ready;
  assign pop         = head_go & ~wipe;
  assign done_hit    = done_valid & vld_q[done_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q  <= '0;
      rdy_q  <= '0;
      flt_q  <= '0;
      mis_q  <= '0;
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else if (wipe) begin
      vld_q  <= '0;
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (pop) begin
        vld_q[head_q] <= 1'b0;
        head_q        <= bump(head_q);
      end
      if (take) begin
        vld_q[tail_q] <= 1'b1;
        rdy_q[tail_q] <= 1'b0;
        flt_q[tail_q] <= 1'b0;
        mis_q[tail_q] <= 1'b0;
        tail_q        <= bump(tail_q);
      end
      if (done_hit) begin
        rdy_q[done_idx] <= 1'b1;
        flt_q[done_idx] <= done_fault;
        mis_q[done_idx] <= done_mispredict;
      end
      cnt_q <= cnt_q + CNT_W'(take) - CNT_W'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      kind_q[tail_q] <= alloc_kind;
      dest_q[tail_q] <= alloc_dest;
    end
    if (done_hit) val_q[done_idx] <= done_value;
  end
endmodule

module commit_queue_chk #(
  parameter int DEPTH = 8,
  parameter int IDX_W = 3,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             alloc_valid,
  input logic             alloc_ready,
  input logic [IDX_W-1:0] alloc_idx,
  input logic             flush_in,
  input logic             commit_reg_we,
  input logic             commit_store,
  input logic             commit_redirect,
  input logic             commit_exc,
  input logic [CNT_W-1:0] cnt_q
);
  p_alloc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && alloc_ready) |=> alloc_idx ==
      (($past(alloc_idx) == IDX_W'(DEPTH - 1)) ? '0 : $past(alloc_idx) + 1'b1));

  p_full_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_W'(DEPTH)) |-> !alloc_ready);

  p_one_action_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({commit_reg_we, commit_store, commit_redirect, commit_exc}));

  p_commit_needs_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_reg_we || commit_store || commit_redirect || commit_exc) |-> cnt_q != '0);

  p_redirect_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    commit_redirect |=> (cnt_q == '0) && (alloc_idx == '0));

  p_fault_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    commit_exc |=> (cnt_q == '0) && (alloc_idx == '0));

  p_flush_mutes_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush_in |-> !commit_reg_we && !commit_store && !alloc_ready);

  p_flush_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush_in |=> (cnt_q == '0) && !commit_reg_we && !commit_store);
endmodule

bind commit_queue commit_queue_chk #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
  .alloc_idx(alloc_idx), .flush_in(flush_in), .commit_reg_we(commit_reg_we),
  .commit_store(commit_store), .commit_redirect(commit_redirect),
  .commit_exc(commit_exc), .cnt_q(cnt_q)
);

// File: tb/commit_queue_test.sv
module commit_queue_test;
  localparam int D = 4, RW = 4, DW = 16, IW = 2;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, alloc_valid, alloc_ready, done_valid, done_fault, done_mispredict, flush_in;
  logic [1:0] alloc_kind;
  logic [RW-1:0] alloc_dest, commit_dest;
  logic [IW-1:0] alloc_idx, done_idx;
  logic [DW-1:0] done_value, commit_value;
  logic commit_reg_we, commit_store, commit_redirect, commit_exc;

  commit_queue #(.DEPTH(D), .REG_W(RW), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_kind(alloc_kind),
    .alloc_dest(alloc_dest), .alloc_ready(alloc_ready), .alloc_idx(alloc_idx),
    .done_valid(done_valid), .done_idx(done_idx), .done_value(done_value),
    .done_fault(done_fault), .done_mispredict(done_mispredict), .flush_in(flush_in),
    .commit_reg_we(commit_reg_we), .commit_dest(commit_dest), .commit_value(commit_value),
    .commit_store(commit_store), .commit_redirect(commit_redirect), .commit_exc(commit_exc)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  bit m_vld[D], m_rdy[D], m_flt[D], m_mis[D];
  logic [1:0] m_kind[D];
  logic [RW-1:0] m_dest[D];
  logic [DW-1:0] m_val[D];
  int m_head = 0, m_tail = 0, m_cnt = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic clear_model();
    for (int i = 0; i < D; i++) m_vld[i] = 0;
    m_head = 0; m_tail = 0; m_cnt = 0;
  endtask

  task automatic tick();
    bit fl, hr, e_exc, e_we, e_st, e_red, e_rdy, dv;
    int di;
    string t;
    #2;
    fl = flush_in;
    hr = m_vld[m_head] && m_rdy[m_head] && !fl;
    e_exc = hr && m_flt[m_head];
    e_we  = hr && !m_flt[m_head] && m_kind[m_head] == 2'b00;
    e_st  = hr && !m_flt[m_head] && m_kind[m_head] == 2'b01;
    e_red = hr && !m_flt[m_head] && m_kind[m_head] == 2'b10 && m_mis[m_head];
    e_rdy = (m_cnt < D) && !fl && !e_exc && !e_red;
    if (fl) t = "R10";
    else if (!hr) t = "R4";
    else if (m_flt[m_head]) t = "R9";
    else if (m_kind[m_head] == 2'b00) t = "R5";
    else if (m_kind[m_head] == 2'b01) t = "R6";
    else if (m_mis[m_head]) t = "R8";
    else t = "R7";
    chk({t, " reg_we"}, 32'(commit_reg_we), 32'(e_we));
    chk({t, " store"}, 32'(commit_store), 32'(e_st));
    chk({t, " redirect"}, 32'(commit_redirect), 32'(e_red));
    chk({t, " exc"}, 32'(commit_exc), 32'(e_exc));
    if (e_we) begin
      chk("R5 dest", 32'(commit_dest), 32'(m_dest[m_head]));
      chk("R5 value", 32'(commit_value), 32'(m_val[m_head]));
    end
    chk((m_cnt == D) ? "R3 ready" : "R2 ready", 32'(alloc_ready), 32'(e_rdy));
    if (e_rdy) chk("R2 idx", 32'(alloc_idx), 32'(m_tail));
    di = int'(done_idx);
    dv = done_valid && m_vld[di];
    @(posedge clk);
    if (fl || e_exc || e_red) clear_model();
    else begin
      if (hr) begin m_vld[m_head] = 0; m_head = (m_head + 1) % D; m_cnt--; end
      if (alloc_valid && e_rdy) begin
        m_vld[m_tail] = 1; m_rdy[m_tail] = 0; m_flt[m_tail] = 0; m_mis[m_tail] = 0;
        m_kind[m_tail] = alloc_kind; m_dest[m_tail] = alloc_dest;
        m_tail = (m_tail + 1) % D; m_cnt++;
      end
      if (dv) begin
        m_rdy[di] = 1; m_flt[di] = done_fault; m_mis[di] = done_mispredict; m_val[di] = done_value;
      end
    end
    #1;
  endtask

  task automatic put(input logic [1:0] k, input logic [RW-1:0] d);
    alloc_valid = 1; alloc_kind = k; alloc_dest = d;
    tick();
    alloc_valid = 0;
  endtask

  task automatic fin(input int idx, input logic [DW-1:0] v, input bit f, input bit m);
    done_valid = 1; done_idx = IW'(idx); done_value = v; done_fault = f; done_mispredict = m;
    tick();
    done_valid = 0; done_fault = 0; done_mispredict = 0;
  endtask

  task automatic drain(input int n);
    repeat (n) tick();
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int s, base;
    int ord[4];
    rst_n = 0; alloc_valid = 0; alloc_kind = 0; alloc_dest = 0;
    done_valid = 0; done_idx = 0; done_value = 0; done_fault = 0; done_mispredict = 0;
    flush_in = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 ready", 32'(alloc_ready), 1);
    chk("R1 idx", 32'(alloc_idx), 0);
    chk("R1 outputs", {28'd0, commit_reg_we, commit_store, commit_redirect, commit_exc}, 0);
    rst_n = 1;
    @(posedge clk); #1;
    chk("R1 after release", 32'(alloc_ready), 1);

    // R4 sweep over every completion order of a full queue (R2, R3, R5-R7)
    s = 0;
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int c = 0; c < 4; c++)
          for (int d = 0; d < 4; d++) begin
            if (a == b || a == c || a == d || b == c || b == d || c == d) continue;
            ord[0] = a; ord[1] = b; ord[2] = c; ord[3] = d;
            base = m_tail;
            for (int i = 0; i < 4; i++) put(2'((s + i) % 3), RW'(s + i));
            put(2'b00, 4'hF);  // R3: refused while full
            for (int k = 0; k < 4; k++)
              fin((base + ord[k]) % D, DW'(s * 37 + ord[k] * 5 + 1), 0, 0);
            drain(2);
            s++;
          end

    // R2 streaming allocate and complete in the same cycle
    for (int i = 0; i < 20; i++) begin
      int prev = (m_tail + D - 1) % D;
      alloc_valid = 1; alloc_kind = 2'b00; alloc_dest = RW'(i);
      if (i > 0) begin
        done_valid = 1; done_idx = IW'(prev); done_value = DW'(1000 + i);
      end
      tick();
    end
    alloc_valid = 0; done_valid = 0;
    drain(3);

    // R7 correct branch then R8 mispredicted branch
    base = m_tail;
    put(2'b10, 1); put(2'b00, 2); put(2'b01, 3);
    fin((base + 2) % D, 16'h0303, 0, 0);
    fin((base + 1) % D, 16'h0202, 0, 0);
    fin(base, 16'h0101, 0, 0);
    drain(3);
    base = m_tail;
    put(2'b10, 4); put(2'b00, 5); put(2'b01, 6);
    fin((base + 1) % D, 16'h0505, 0, 0);
    fin((base + 2) % D, 16'h0606, 0, 0);
    fin(base, 16'h0404, 0, 1);
    tick();
    chk("R8 idx after redirect", 32'(alloc_idx), 0);
    chk("R8 ready after redirect", 32'(alloc_ready), 1);
    drain(2);

    // R9 faults on a register entry and on a store entry
    put(2'b00, 7); put(2'b01, 8);
    fin(1, 16'h0808, 0, 0);
    fin(0, 16'h0707, 1, 0);
    drain(3);
    chk("R9 idx after fault", 32'(alloc_idx), 0);
    put(2'b01, 9);
    fin(0, 16'h0909, 1, 0);
    drain(2);

    // R10 external flush while the head is ready
    put(2'b00, 10); put(2'b00, 11); put(2'b00, 12);
    fin(0, 16'h0A0A, 0, 0);
    flush_in = 1;
    tick();
    flush_in = 0;
    chk("R10 idx after flush", 32'(alloc_idx), 0);
    drain(2);

    // R11 stray completion to an unallocated entry
    fin(2, 16'hDEAD, 0, 0);
    put(2'b00, 1); put(2'b00, 2); put(2'b00, 3);
    fin(0, 16'h1111, 0, 0);
    fin(1, 16'h2222, 0, 0);
    drain(3);
    chk("R11 entry still waiting", 32'(commit_reg_we), 0);
    fin(2, 16'h3333, 0, 0);
    drain(2);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule